// File: doc/BRIEF.md
# Up/Down Period Timer with Deferred Command Register

This block is a single-clock timer/counter that advances only on cycles where a prescaler enable input is high. It counts up from zero to an active period value, or down from that period to zero, and wraps at the boundary. Each wrap is the block's update condition. A compare value is matched against the count. Period and compare each have a buffer register. The buffers reach the active registers when a wrap occurs, unless software has locked updates. A forced update command copies them whatever the lock says.

Software drives the block through a pair of write ports that act on one control byte. One port sets bits where a 1 is written. The other clears bits where a 1 is written. Posted commands wait for the next prescaler tick and then clear themselves. The commands are restart, stop, forced buffer copy, count snapshot and a single-cycle DMA request. A separate two-bit field steers the A/B ramp index at the next wrap. It can let the index toggle, force cycle B, force cycle A or hold the current cycle. A one-shot bit makes the timer halt at its next wrap.

Top module: `tctr_top`

## Requirements
- R1: After reset the control byte reads 0x00, the count is 0, the index is 0 (cycle A), the stopped flag is 0, the DMA pulse is 0 and the snapshot is 0. The active period and compare take their parameter initial values.
- R2: With the direction bit (control bit 0) at 0, each tick adds one to the count. A tick at a count equal to or above the active period gives 0 instead. Without a tick the count does not change.
- R3: With the direction bit at 1, each tick subtracts one from the count. A tick at a count of 0 loads the active period.
- R4: The set port ORs its data into control bits 2:0: bit 2 is one-shot, bit 1 is update lock, bit 0 is direction. The clear port clears each of those bits where its data is 1. Data bits at 0 change nothing.
- R5: A nonzero value written through the set port to bits 7:5 posts a command. Codes: 1 restart, 2 stop, 3 forced update, 4 snapshot, 5 DMA pulse. The command does nothing until a tick. At that tick it executes and bits 7:5 read 0 afterwards.
- R6: Writing 1 to any of bits 7:5 through the clear port cancels a pending command, so the next tick acts as if none was posted. Writing 1 to any of bits 4:3 through the clear port cancels a pending index command.
- R7: Restart loads 0 when counting up, or the active period when counting down, and clears the stopped flag.
- R8: Stop sets the stopped flag. While stopped, the count does not move on ticks until a restart.
- R9: A forced update copies the period and compare buffers into the active registers at its tick, even with the update lock set.
- R10: At a wrap the buffers are copied into the active registers when the update lock is 0, and are not copied when it is 1.
- R11: At each wrap the index follows control bits 4:3: 0 toggles it, 1 forces 1 (cycle B), 2 forces 0 (cycle A), 3 keeps it. A nonzero field clears itself at that wrap.
- R12: With the one-shot bit set, a wrap still loads the wrapped count and also sets the stopped flag.
- R13: A snapshot command copies the pre-tick count into the snapshot output. A DMA command raises the DMA output for exactly the one cycle after its tick.
- R14: The match output is 1 exactly when the count equals the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaler enable; one count step or command execution per high cycle |
| reg_wr_set | input | 1 | Write-1-to-set strobe for the control byte |
| reg_wr_clr | input | 1 | Write-1-to-clear strobe for the control byte |
| reg_wdata | input | 8 | Data for either control strobe |
| ctrl_rdata | output | 8 | Control byte readback |
| buf_per_wr | input | 1 | Write strobe for the period buffer |
| buf_per_data | input | W | Period buffer data |
| buf_cmp_wr | input | 1 | Write strobe for the compare buffer |
| buf_cmp_data | input | W | Compare buffer data |
| count | output | W | Current count |
| cmp_match | output | 1 | Count equals active compare |
| idx | output | 1 | Ramp index, 0 cycle A, 1 cycle B |
| stopped | output | 1 | Counter halted |
| dma_trig | output | 1 | Single-cycle DMA request |
| count_snap | output | W | Count captured by the snapshot command |

## Verification
A wrong active period shows at the first wrap after the bad copy: the count falls back to zero, or reloads on a down count, at the wrong step. The full-cycle sweeps catch that within one period. A pending command that fails to clear, or that executes without a tick, shows in the control readback in the next cycle, or as a restart or stop that moves the count at the next tick. A wrong index update shows on the index output in the cycle after the wrap it belongs to. The bench checks the index after every wrap under each index command.

// File: rtl/tctr_pkg.sv
// Package: shared constants for the command timer.
// Assumes an 8-bit control byte whose field positions are fixed by software.
package tctr_pkg;
    localparam int CTRL_W   = 8;
    localparam int CMD_LSB  = 5;
    localparam int IXC_LSB  = 3;
    localparam int BIT_ONE  = 2;
    localparam int BIT_LOCK = 1;
    localparam int BIT_DIR  = 0;

    localparam logic [2:0] CMD_NONE   = 3'd0;
    localparam logic [2:0] CMD_RESTRT = 3'd1;
    localparam logic [2:0] CMD_HALT   = 3'd2;
    localparam logic [2:0] CMD_FUPD   = 3'd3;
    localparam logic [2:0] CMD_SNAP   = 3'd4;
    localparam logic [2:0] CMD_DMA    = 3'd5;

    localparam logic [1:0] IXC_TOGGLE = 2'd0;
    localparam logic [1:0] IXC_FORCEB = 2'd1;
    localparam logic [1:0] IXC_FORCEA = 2'd2;
    localparam logic [1:0] IXC_KEEP   = 2'd3;
endpackage

// File: rtl/tctr_ctrl.sv
// Module: control byte with set/clear write ports and self-clearing command fields.
// Assumes tick and wrap come from the counter core in the same cycle they take effect.
// If set and clear are written together, the set port wins for the command fields.
module tctr_ctrl
    import tctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              tick,
    input  logic              wrap,
    output logic [CTRL_W-1:0] rdata,
    output logic [2:0]        cmd,
    output logic [1:0]        ixc,
    output logic              one_shot,
    output logic              upd_lock,
    output logic              dir_down
);
    logic [2:0] cmd_n;
    logic [1:0] ixc_n;
    logic [2:0] mode_q, mode_n;
    logic [2:0] w_cmd;
    logic [1:0] w_ixc;
    logic [2:0] w_mode;

    assign w_cmd  = wdata[CMD_LSB +: 3];
    assign w_ixc  = wdata[IXC_LSB +: 2];
    assign w_mode = wdata[2:0];

    // Next state: retire executed commands, then apply clear and set writes.
    always_comb begin
        cmd_n  = cmd;
        ixc_n  = ixc;
        mode_n = mode_q;
        if (tick && cmd != CMD_NONE) cmd_n = CMD_NONE;
        if (wrap) ixc_n = IXC_TOGGLE;
        if (wr_clr) begin
            if (w_cmd != 3'd0) cmd_n = CMD_NONE;
            if (w_ixc != 2'd0) ixc_n = IXC_TOGGLE;
            mode_n = mode_n & ~w_mode;
        end
        if (wr_set) begin
            if (w_cmd != 3'd0) cmd_n = w_cmd;
            if (w_ixc != 2'd0) ixc_n = w_ixc;
            mode_n = mode_n | w_mode;
        end
    end

    // Control byte register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd    <= CMD_NONE;
            ixc    <= IXC_TOGGLE;
            mode_q <= 3'b000;
        end else begin
            cmd    <= cmd_n;
            ixc    <= ixc_n;
            mode_q <= mode_n;
        end
    end

    assign one_shot = mode_q[BIT_ONE];
    assign upd_lock = mode_q[BIT_LOCK];
    assign dir_down = mode_q[BIT_DIR];
    assign rdata    = {cmd, ixc, mode_q};

    AST_CMD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmd != CMD_NONE && !wr_set) |=> (cmd == CMD_NONE)); // R5
    AST_CMD_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_set && !wr_clr) |=> $stable(cmd)); // R5
endmodule

// File: rtl/tctr_core.sv
// Module: counter, double-buffered period/compare, ramp index and command execution.
// Assumes commands arrive already decoded from the control byte and act only on ticks.
module tctr_core
    import tctr_pkg::*;
#(
    parameter int          W        = 8,
    parameter logic [W-1:0] PER_INIT = '1,
    parameter logic [W-1:0] CMP_INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [2:0]   cmd,
    input  logic [1:0]   ixc,
    input  logic         one_shot,
    input  logic         upd_lock,
    input  logic         dir_down,
    input  logic         per_wr,
    input  logic [W-1:0] per_din,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_din,
    output logic [W-1:0] count,
    output logic         match,
    output logic         idx,
    output logic         stopped,
    output logic         dma_trig,
    output logic [W-1:0] snap,
    output logic         wrap
);
    logic [W-1:0] per_q, cmp_q, per_buf, cmp_buf;
    logic [W-1:0] per_nxt, count_n;
    logic [2:0]   exec;
    logic         halt, at_edge, copy, idx_n;

    // Decode the command in effect this cycle and the wrap/copy conditions.
    always_comb begin
        exec    = tick ? cmd : CMD_NONE;
        halt    = stopped || exec == CMD_HALT || exec == CMD_RESTRT;
        at_edge = dir_down ? (count == '0) : (count >= per_q);
        wrap    = tick && !halt && at_edge;
        copy    = (exec == CMD_FUPD) || (wrap && !upd_lock);
        per_nxt = copy ? per_buf : per_q;
    end

    // Next count: restart load, wrap load or single step.
    always_comb begin
        count_n = count;
        if (exec == CMD_RESTRT) begin
            count_n = dir_down ? per_q : '0;
        end else if (tick && !halt) begin
            if (wrap) count_n = dir_down ? per_nxt : '0;
            else      count_n = dir_down ? count - 1'b1 : count + 1'b1;
        end
    end

    // Next ramp index at a wrap, steered by the index command.
    always_comb begin
        idx_n = idx;
        if (wrap) begin
            case (ixc)
                IXC_FORCEB: idx_n = 1'b1;
                IXC_FORCEA: idx_n = 1'b0;
                IXC_KEEP:   idx_n = idx;
                default:    idx_n = ~idx;
            endcase
        end
    end

    // Buffer registers written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_buf <= PER_INIT;
            cmp_buf <= CMP_INIT;
        end else begin
            if (per_wr) per_buf <= per_din;
            if (cmp_wr) cmp_buf <= cmp_din;
        end
    end

    // Active period/compare, loaded from the buffers on a copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= PER_INIT;
            cmp_q <= CMP_INIT;
        end else if (copy) begin
            per_q <= per_buf;
            cmp_q <= cmp_buf;
        end
    end

    // Count, index and stopped state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            idx     <= 1'b0;
            stopped <= 1'b0;
        end else begin
            count <= count_n;
            idx   <= idx_n;
            if (exec == CMD_RESTRT)          stopped <= 1'b0;
            else if (exec == CMD_HALT)       stopped <= 1'b1;
            else if (wrap && one_shot)       stopped <= 1'b1;
        end
    end

    // Snapshot capture and single-cycle DMA request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap     <= '0;
            dma_trig <= 1'b0;
        end else begin
            if (exec == CMD_SNAP) snap <= count;
            dma_trig <= (exec == CMD_DMA);
        end
    end

    assign match = (count == cmp_q);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R2
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !(tick && cmd == CMD_RESTRT)) |=> $stable(count)); // R8
    AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmd == CMD_RESTRT) |=> !stopped); // R7
    AST_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ixc == IXC_KEEP) |=> $stable(idx)); // R11
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && one_shot) |=> stopped); // R12
endmodule

// File: rtl/tctr_top.sv
// Module: top of the command timer; joins the control byte and the counter core.
// Assumes a single clock and a tick input already produced by a prescaler.
module tctr_top
    import tctr_pkg::*;
#(
    parameter int          W        = 8,
    parameter logic [W-1:0] PER_INIT = '1,
    parameter logic [W-1:0] CMP_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr_set,
    input  logic              reg_wr_clr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              buf_per_wr,
    input  logic [W-1:0]      buf_per_data,
    input  logic              buf_cmp_wr,
    input  logic [W-1:0]      buf_cmp_data,
    output logic [W-1:0]      count,
    output logic              cmp_match,
    output logic              idx,
    output logic              stopped,
    output logic              dma_trig,
    output logic [W-1:0]      count_snap
);
    logic [2:0] cmd;
    logic [1:0] ixc;
    logic       one_shot, upd_lock, dir_down, wrap;

    tctr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_set   (reg_wr_set),
        .wr_clr   (reg_wr_clr),
        .wdata    (reg_wdata),
        .tick     (tick),
        .wrap     (wrap),
        .rdata    (ctrl_rdata),
        .cmd      (cmd),
        .ixc      (ixc),
        .one_shot (one_shot),
        .upd_lock (upd_lock),
        .dir_down (dir_down)
    );

    tctr_core #(.W(W), .PER_INIT(PER_INIT), .CMP_INIT(CMP_INIT)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd      (cmd),
        .ixc      (ixc),
        .one_shot (one_shot),
        .upd_lock (upd_lock),
        .dir_down (dir_down),
        .per_wr   (buf_per_wr),
        .per_din  (buf_per_data),
        .cmp_wr   (buf_cmp_wr),
        .cmp_din  (buf_cmp_data),
        .count    (count),
        .match    (cmp_match),
        .idx      (idx),
        .stopped  (stopped),
        .dma_trig (dma_trig),
        .snap     (count_snap),
        .wrap     (wrap)
    );
endmodule

// File: tb/tb_tctr_top.sv
module tb_tctr_top;
    localparam int W = 8;
    localparam int CLK_NS = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         reg_wr_set = 1'b0, reg_wr_clr = 1'b0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   ctrl_rdata;
    logic         buf_per_wr = 1'b0, buf_cmp_wr = 1'b0;
    logic [W-1:0] buf_per_data = '0, buf_cmp_data = '0;
    logic [W-1:0] count, count_snap;
    logic         cmp_match, idx, stopped, dma_trig;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    tctr_top #(.W(W), .PER_INIT(8'd5), .CMP_INIT(8'd2)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reg_wr_set(reg_wr_set), .reg_wr_clr(reg_wr_clr), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata),
        .buf_per_wr(buf_per_wr), .buf_per_data(buf_per_data),
        .buf_cmp_wr(buf_cmp_wr), .buf_cmp_data(buf_cmp_data),
        .count(count), .cmp_match(cmp_match), .idx(idx), .stopped(stopped),
        .dma_trig(dma_trig), .count_snap(count_snap)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_set(input logic [7:0] d);
        reg_wr_set = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_set = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_clr(input logic [7:0] d);
        reg_wr_clr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_clr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_buf(input logic [W-1:0] p, input logic [W-1:0] c);
        buf_per_wr = 1'b1; buf_per_data = p;
        buf_cmp_wr = 1'b1; buf_cmp_data = c;
        @(negedge clk);
        buf_per_wr = 1'b0; buf_cmp_wr = 1'b0;
    endtask

    task automatic tk();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic tk_n(input int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", int'(ctrl_rdata), 0);
        chk("R1 count", int'(count), 0);
        chk("R1 idx", int'(idx), 0);
        chk("R1 stopped", int'(stopped), 0);
        chk("R1 dma", int'(dma_trig), 0);
        chk("R1 snap", int'(count_snap), 0);
        chk("R14 match at reset", int'(cmp_match), 0);

        // R4 set/clear of mode bits, zero bits untouched
        wr_set(8'h07); chk("R4 set", int'(ctrl_rdata), 8'h07);
        wr_clr(8'h00); chk("R4 clr zero", int'(ctrl_rdata), 8'h07);
        wr_clr(8'h05); chk("R4 clr part", int'(ctrl_rdata), 8'h02);
        wr_set(8'h00); chk("R4 set zero", int'(ctrl_rdata), 8'h02);
        wr_clr(8'h02); chk("R4 clr all", int'(ctrl_rdata), 8'h00);

        // R2 idle cycles do not move the count
        repeat (3) @(negedge clk);
        chk("R2 no tick", int'(count), 0);

        // R2/R14 full up sweep with period 5, compare 2
        for (int k = 1; k <= 18; k++) begin
            tk();
            chk("R2 up", int'(count), k % 6);
            chk("R14 match", int'(cmp_match), int'((k % 6) == 2));
        end
        chk("R11 toggle x3", int'(idx), 1);

        // R5/R9 forced update under lock
        wr_buf(8'd3, 8'd1);
        wr_set(8'h02);
        wr_set(8'h60);
        chk("R5 posted", int'(ctrl_rdata), 8'h62);
        repeat (2) @(negedge clk);
        chk("R5 waits tick", int'(ctrl_rdata), 8'h62);
        chk("R5 no exec", int'(count), 0);
        tk();
        chk("R5 retired", int'(ctrl_rdata), 8'h02);
        chk("R5 count step", int'(count), 1);
        chk("R9 new cmp", int'(cmp_match), 1);
        tk(); chk("R9 step", int'(count), 2);
        tk(); chk("R9 step", int'(count), 3);
        tk(); chk("R9 wrap at 3", int'(count), 0);

        // R10 lock blocks wrap copy, unlock allows it
        wr_buf(8'd6, 8'd1);
        for (int k = 1; k <= 4; k++) begin
            tk(); chk("R10 locked", int'(count), k % 4);
        end
        wr_clr(8'h02);
        for (int k = 1; k <= 4; k++) begin
            tk(); chk("R10 copy wrap", int'(count), k % 4);
        end
        for (int k = 1; k <= 7; k++) begin
            tk(); chk("R10 new period", int'(count), k % 7);
        end

        // R3 down sweep with period 6
        wr_set(8'h01);
        for (int k = 1; k <= 14; k++) begin
            tk(); chk("R3 down", int'(count), (7 - (k % 7)) % 7);
        end

        // R7 restart in both directions
        tk(); tk();
        wr_set(8'h20); tk();
        chk("R7 down restart", int'(count), 6);
        wr_clr(8'h01);
        wr_set(8'h20); tk();
        chk("R7 up restart", int'(count), 0);

        // R6 cancel a pending stop
        wr_set(8'h40);
        wr_clr(8'hE0);
        chk("R6 cancelled", int'(ctrl_rdata), 0);
        tk();
        chk("R6 count runs", int'(count), 1);
        chk("R6 not stopped", int'(stopped), 0);

        // R8 stop freezes, R7 restart resumes
        wr_set(8'h40); tk();
        chk("R8 stopped", int'(stopped), 1);
        chk("R8 count", int'(count), 1);
        tk_n(4);
        chk("R8 frozen", int'(count), 1);
        wr_set(8'h20); tk();
        chk("R7 resumes", int'(stopped), 0);
        chk("R7 count", int'(count), 0);

        // R12 one-shot halts at the wrap
        wr_set(8'h04);
        chk("R12 bit", int'(ctrl_rdata), 8'h04);
        tk_n(6);
        chk("R12 before wrap", int'(count), 6);
        tk();
        chk("R12 wrapped", int'(count), 0);
        chk("R12 halted", int'(stopped), 1);
        tk_n(3);
        chk("R12 stays", int'(count), 0);
        wr_clr(8'h04);
        wr_set(8'h20); tk();
        chk("R12 restarted", int'(stopped), 0);

        // R11 index commands, each judged after one full period
        base = int'(idx);
        wr_set(8'h18);
        chk("R11 posted", int'(ctrl_rdata), 8'h18);
        tk_n(7);
        chk("R11 keep", int'(idx), base);
        chk("R11 field clears", int'(ctrl_rdata), 0);
        wr_set(8'h08); tk_n(7);
        chk("R11 force B", int'(idx), 1);
        tk_n(7);
        chk("R11 toggle", int'(idx), 0);
        wr_set(8'h10); tk_n(7);
        chk("R11 force A", int'(idx), 0);
        tk_n(7);
        chk("R11 toggle", int'(idx), 1);
        wr_set(8'h10); wr_clr(8'h18);
        chk("R6 idx cancel", int'(ctrl_rdata), 0);
        tk_n(7);
        chk("R6 idx toggles", int'(idx), 0);

        // R13 snapshot and DMA pulse
        tk_n(3);
        chk("R13 pre", int'(count), 3);
        wr_set(8'h80); tk();
        chk("R13 snap", int'(count_snap), 3);
        chk("R13 count", int'(count), 4);
        chk("R13 no dma", int'(dma_trig), 0);
        wr_set(8'hA0); tk();
        chk("R13 dma high", int'(dma_trig), 1);
        @(negedge clk);
        chk("R13 dma low", int'(dma_trig), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule